// File: doc/BRIEF.md
# Two-Phase Unipolar Stepper Phase Sequencer

This block turns step and direction commands into the four winding enables of a two-phase unipolar stepper motor. It keeps a three-bit position index on a ring of eight electrical positions 45 degrees apart. Each falling edge of the step input moves the index one position forward or back. The index is decoded into active-high enables for the two halves of phase A and the two halves of phase B. The step, direction, step-size and inhibit inputs arrive from outside the clock domain, so each one passes through a synchroniser chain before any logic uses it.

Two step sizes are available. In half-step operation the index visits all eight positions, so one and two energised windings alternate. In full-step operation only the odd positions are used, and these form a four-state Gray-code cycle with two windings always on. Two zero indicators report which phase the half-step pattern has switched off at the present position. A host can read them to find out whether a change to full-step operation will lose position. An inhibit input switches all four windings off and keeps the position for later.

Top module: `stepper_phase_seq`

## Requirements
- R1: Each falling edge of `stepIn` moves the index by exactly one step. A rising edge, a held level, or any change on `dirIn` or `halfIn` leaves the outputs unchanged.
- R2: `dirIn` and `halfIn` are taken at the moment the falling edge of `stepIn` is detected. With `dirIn` high the index increases (modulo 8), and with `dirIn` low it decreases.
- R3: With `halfIn` low each step moves the index by one. The index decodes as follows, shown as {pa1,pa2,pb1,pb2}: 0=1000, 1=1010, 2=0010, 3=0110, 4=0100, 5=0101, 6=0001, 7=1001.
- R4: With `halfIn` high and the index odd, each step moves the index by two. Forward, the outputs cycle 1010, 0110, 0101, 1001, and reverse runs the same cycle backward.
- R5: With `halfIn` high and the index even (the first full step after half-step operation), the step moves the index by one in the commanded direction, to the nearest two-winding state.
- R6: A high `inhIn` forces all four winding enables low. The index is kept, and falling edges of `stepIn` are ignored while the inhibit is in effect. When inhibit is released, the pattern of the held index returns.
- R7: `za` is high exactly at indexes 2 and 6, where phase A is off. `zb` is high exactly at indexes 0 and 4, where phase B is off. Both indicators follow the index whether or not inhibit is active.
- R8: `pa1` and `pa2` are never high together, and `pb1` and `pb2` are never high together.
- R9: While `rstN` is low all six outputs are low and the index is 0. The synchronisers reset to the high level, so a step input that is held high through reset release does not cause a step. After release with `inhIn` low the outputs show index 0 (`pa1` and `zb` high).
- R10: With the default two-stage synchroniser, a falling edge of `stepIn` set up before a rising clock edge reaches the outputs at the third rising edge. A change on `inhIn` reaches the winding enables at the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepIn | input | 1 | Step command; one step per falling edge |
| dirIn | input | 1 | Direction: high increments, low decrements |
| halfIn | input | 1 | Step size: low half step, high full step |
| inhIn | input | 1 | Inhibit: high switches all windings off |
| pa1 | output | 1 | Phase A first-half winding enable |
| pa2 | output | 1 | Phase A second-half winding enable |
| pb1 | output | 1 | Phase B first-half winding enable |
| pb2 | output | 1 | Phase B second-half winding enable |
| za | output | 1 | Phase A switched off by the half-step pattern |
| zb | output | 1 | Phase B switched off by the half-step pattern |

## Verification
The assertions check the following on every cycle: the two halves of a phase are never on together; inhibit blanks all windings; an indicator is high only when its own phase is off and the other phase is on; the index holds between step strobes; a half step toggles between one-winding and two-winding states; and a full step always lands on a two-winding state. Other behaviour can only be shown by the bench's scenarios. These include the exact order of the table in both directions, the adjustment by one position when changing from half to full step, the sampling of direction and step size only at the edge, the exact latency through the synchronisers, and the position held across an inhibit. The bench sweeps every index in each mode and direction and compares the outputs against membership sets it computes itself.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int IDX_W = 3;
  localparam int N_POS = 1 << IDX_W;

  typedef struct packed {
    logic advance;   // one-cycle step strobe
    logic dirFwd;    // direction captured with the strobe
    logic fullMode;  // step size captured with the strobe
    logic outOff;    // windings blanked (synchronised inhibit)
    logic live;      // reset released, indicators valid
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import stepper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic       halfIn,
  input  logic       inhIn,
  output seqStrobe_t strb
);
  localparam int NIN = 4;
  localparam logic [NIN-1:0] RST_LEVEL = '1;  // undriven inputs resolve high

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] syncd;
  logic           stepPrev;
  logic           liveQ;
  logic           stepFall;

  assign rawIn = {inhIn, halfIn, dirIn, stepIn};

  for (genvar g = 0; g < NIN; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{RST_LEVEL[g]}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPrev <= 1'b1;
      liveQ    <= 1'b0;
    end else begin
      stepPrev <= syncd[0];
      liveQ    <= 1'b1;
    end
  end

  assign stepFall = stepPrev & ~syncd[0];

  always_comb begin
    strb.advance  = stepFall & ~syncd[3] & liveQ;
    strb.dirFwd   = syncd[1];
    strb.fullMode = syncd[2];
    strb.outOff   = syncd[3];
    strb.live     = liveQ;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       pa1,
  output logic       pa2,
  output logic       pb1,
  output logic       pb2,
  output logic       za,
  output logic       zb
);
  logic [IDX_W-1:0] posIdx;
  logic [IDX_W-1:0] stride;
  logic [IDX_W-1:0] nextIdx;
  logic [3:0]       pattern;

  // Full step from an odd position jumps two; otherwise one.
  always_comb begin
    stride  = (strb.fullMode && posIdx[0]) ? IDX_W'(2) : IDX_W'(1);
    nextIdx = strb.dirFwd ? posIdx + stride : posIdx - stride;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             posIdx <= '0;
    else if (strb.advance) posIdx <= nextIdx;
  end

  // {a1, a2, b1, b2}
  always_comb begin
    unique case (posIdx)
      3'd0: pattern = 4'b1000;
      3'd1: pattern = 4'b1010;
      3'd2: pattern = 4'b0010;
      3'd3: pattern = 4'b0110;
      3'd4: pattern = 4'b0100;
      3'd5: pattern = 4'b0101;
      3'd6: pattern = 4'b0001;
      default: pattern = 4'b1001;
    endcase
  end

  assign pa1 = pattern[3] & ~strb.outOff;
  assign pa2 = pattern[2] & ~strb.outOff;
  assign pb1 = pattern[1] & ~strb.outOff;
  assign pb2 = pattern[0] & ~strb.outOff;
  assign za  = strb.live & ~(pattern[3] | pattern[2]);
  assign zb  = strb.live & ~(pattern[1] | pattern[0]);
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic stepIn,
  input  logic dirIn,
  input  logic halfIn,
  input  logic inhIn,
  output logic pa1,
  output logic pa2,
  output logic pb1,
  output logic pb2,
  output logic za,
  output logic zb
);
  seqStrobe_t strb;

  seq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn),
    .halfIn(halfIn), .inhIn(inhIn), .strb(strb)
  );

  seq_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pa1(pa1), .pa2(pa2), .pb1(pb1), .pb2(pb2), .za(za), .zb(zb)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import stepper_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       pa1,
  input logic       pa2,
  input logic       pb1,
  input logic       pb2,
  input logic       za,
  input logic       zb,
  input seqStrobe_t strb
);
  assert_exclusive_halves_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(pa1 && pa2) && !(pb1 && pb2));

  assert_inhibit_blanks_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.outOff |-> !(pa1 || pa2 || pb1 || pb2));

  assert_zero_a_meaning_R7: assert property (@(posedge clk) disable iff (!rstN)
    (za && !strb.outOff) |-> (!pa1 && !pa2 && (pb1 ^ pb2)));

  assert_zero_b_meaning_R7: assert property (@(posedge clk) disable iff (!rstN)
    (zb && !strb.outOff) |-> (!pb1 && !pb2 && (pa1 ^ pa2)));

  assert_hold_without_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.live && !strb.advance) |=> ($stable(za) && $stable(zb)));

  assert_half_alternates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.fullMode) |=> ((za || zb) != $past(za || zb)));

  assert_full_lands_two_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.fullMode) |=> (!za && !zb));
endmodule

bind stepper_phase_seq seq_checker chk_i (
  .clk(clk), .rstN(rstN), .pa1(pa1), .pa2(pa2), .pb1(pb1), .pb2(pb2),
  .za(za), .zb(zb), .strb(strb)
);

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepIn = 1'b1, dirIn = 1'b1, halfIn = 1'b0, inhIn = 1'b0;
  logic pa1, pa2, pb1, pb2, za, zb;
  int total = 0, bad = 0;
  int mIdx = 0;
  logic mInh = 1'b0;

  always #5 clk = ~clk;

  stepper_phase_seq dut_i (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn), .halfIn(halfIn),
    .inhIn(inhIn), .pa1(pa1), .pa2(pa2), .pb1(pb1), .pb2(pb2), .za(za), .zb(zb)
  );

  function automatic logic [5:0] expVec(int idx, logic inh);
    logic a1, a2, b1, b2;
    a1 = (idx == 7) || (idx == 0) || (idx == 1);
    a2 = (idx >= 3) && (idx <= 5);
    b1 = (idx >= 1) && (idx <= 3);
    b2 = (idx >= 5) && (idx <= 7);
    if (inh) {a1, a2, b1, b2} = 4'b0000;
    return {a1, a2, b1, b2, (idx == 2) || (idx == 6), (idx == 0) || (idx == 4)};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b (model index %0d)", req, act, exp, mIdx);
    end
  endtask

  function automatic logic [5:0] outs();
    return {pa1, pa2, pb1, pb2, za, zb};
  endfunction

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStep(logic d, logic h, string req);
    int stride;
    dirIn = d; halfIn = h;
    waitNeg(2);
    stepIn = 1'b0;
    waitNeg(2);
    stepIn = 1'b1;
    waitNeg(3);
    if (!mInh) begin
      stride = (h && (mIdx % 2 == 1)) ? 2 : 1;
      mIdx = d ? (mIdx + stride) % 8 : (mIdx + 8 - stride) % 8;
    end
    chk(req, outs(), expVec(mIdx, mInh));
  endtask

  initial begin
    waitNeg(3);
    chk("R9 in reset", outs(), 6'b000000);
    rstN = 1'b1;
    waitNeg(4);
    chk("R9 after release", outs(), expVec(0, 1'b0));

    // R3 half-step forward sweep over two revolutions, then reverse
    for (int i = 0; i < 16; i++) doStep(1'b1, 1'b0, "R3 half fwd");
    for (int i = 0; i < 16; i++) doStep(1'b0, 1'b0, "R2 half rev");

    // R5: index even, switch to full step forward, then full sweep R4
    doStep(1'b1, 1'b1, "R5 half-to-full fwd");
    for (int i = 0; i < 8; i++) doStep(1'b1, 1'b1, "R4 full fwd");
    for (int i = 0; i < 8; i++) doStep(1'b0, 1'b1, "R4 full rev");
    doStep(1'b0, 1'b0, "R3 back to half");
    doStep(1'b0, 1'b1, "R5 half-to-full rev");

    // R1/R2: direction and mode changes without a step do nothing
    dirIn = ~dirIn; halfIn = ~halfIn;
    waitNeg(6);
    dirIn = ~dirIn; waitNeg(6);
    chk("R1 no edge no move", outs(), expVec(mIdx, 1'b0));

    // R2: DIR changed right after the falling edge is not used for that step
    dirIn = 1'b1; halfIn = 1'b0; waitNeg(3);
    stepIn = 1'b0; waitNeg(3); dirIn = 1'b0;
    waitNeg(3); stepIn = 1'b1; waitNeg(3);
    mIdx = (mIdx + 1) % 8;
    chk("R2 sampled at edge", outs(), expVec(mIdx, 1'b0));

    // R10: step latency
    dirIn = 1'b1; halfIn = 1'b0; waitNeg(3);
    stepIn = 1'b0;
    waitNeg(2);
    chk("R10 before third edge", outs(), expVec(mIdx, 1'b0));
    waitNeg(1);
    mIdx = (mIdx + 1) % 8;
    chk("R10 at third edge", outs(), expVec(mIdx, 1'b0));
    stepIn = 1'b1; waitNeg(3);

    // R6/R10: inhibit latency, held index, ignored steps
    inhIn = 1'b1;
    waitNeg(1);
    chk("R10 inhibit not yet", outs(), expVec(mIdx, 1'b0));
    waitNeg(1);
    mInh = 1'b1;
    chk("R6 inhibit blanks", outs(), expVec(mIdx, 1'b1));
    doStep(1'b1, 1'b0, "R6 step ignored");
    doStep(1'b1, 1'b1, "R7 indicators under inhibit");
    inhIn = 1'b0; mInh = 1'b0;
    waitNeg(3);
    chk("R6 resume same index", outs(), expVec(mIdx, 1'b0));
    for (int i = 0; i < 8; i++) doStep(1'b1, 1'b0, "R8 exclusive sweep");

    // R9: reset mid-sequence with step held high
    rstN = 1'b0; waitNeg(2);
    chk("R9 reset clears outputs", outs(), 6'b000000);
    rstN = 1'b1; mIdx = 0;
    waitNeg(5);
    chk("R9 no false step", outs(), expVec(0, 1'b0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule